// File: doc/BRIEF.md
# Pipeline Control Carrier

This block moves each instruction's decoded control bits and its destination register number down a five-stage in-order pipeline. The stages are fetch, decode, execute, memory and writeback. An external decoder presents three control groups during decode, together with a valid flag and the two candidate destination fields. The execute group holds the operand-B source select, the ALU operation code and the destination select. The memory group holds branch, load and store. The writeback group holds the register-file write enable and the load-result select.

On every clock edge each bundle moves one stage forward. Each group is dropped once the stage that uses it has passed. The execute group lives only in the ID/EX register. The memory group lives through EX/MEM. Only the writeback group reaches MEM/WB.

The destination register is chosen in execute. The chosen number then travels with its instruction, so the register-file write address at writeback always belongs to the instruction that is writing. In the memory stage the block also presents the ALU zero flag captured at the end of execute, and a taken-branch strobe for an external next-PC mux.

Top module: `pipeCtlShifter`

## Requirements
- R1: The execute outputs `exAluSrc` and `exAluOp` show the execute group of an instruction exactly one clock edge after that instruction is captured at decode.
- R2: In execute, `exDstReg` equals `idRdField` when the captured destination select `idRegDst` is 1, and `idRtField` when it is 0. The rt field is instruction bits 20 to 16 and the rd field is bits 15 to 11.
- R3: `memBranch`, `memRead` and `memWrite` show the memory group of an instruction two clock edges after it is captured.
- R4: `memZero` equals the `exZero` value sampled at the edge that ends that instruction's execute cycle. `memTakeBranch` is `memBranch` AND `memZero`.
- R5: `wbRegWrite` and `wbMemToReg` show the writeback group of an instruction three clock edges after it is captured. The register write commits at the end of that writeback cycle.
- R6: `wbDstReg` is the destination number chosen in execute for the same instruction, carried two more edges. This holds even when every instruction in a back-to-back stream has a different destination.
- R7: A slot captured with `idValid` = 0 carries all-zero control through every stage. It therefore never raises register write, load or store.
- R8: A high `rst` at a clock edge clears every stage register's control bits and destination number to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| idValid | input | 1 | Decode slot holds a real instruction |
| idAluSrc | input | 1 | Operand-B source select from the decoder |
| idAluOp | input | ALU_OP_W | ALU operation code from the decoder |
| idRegDst | input | 1 | Destination select: 1 picks the rd field, 0 picks the rt field |
| idBranch | input | 1 | Instruction is a conditional branch |
| idMemRead | input | 1 | Instruction loads from data memory |
| idMemWrite | input | 1 | Instruction stores to data memory |
| idRegWrite | input | 1 | Instruction writes the register file |
| idMemToReg | input | 1 | Writeback value comes from memory |
| idRtField | input | REG_W | Instruction bits 20 to 16 |
| idRdField | input | REG_W | Instruction bits 15 to 11 |
| exZero | input | 1 | ALU zero flag of the instruction in execute |
| exAluSrc | output | 1 | Operand-B select for the execute stage |
| exAluOp | output | ALU_OP_W | ALU operation for the execute stage |
| exDstReg | output | REG_W | Destination chosen in execute |
| memBranch | output | 1 | Branch flag in the memory stage |
| memRead | output | 1 | Load strobe in the memory stage |
| memWrite | output | 1 | Store strobe in the memory stage |
| memZero | output | 1 | Zero flag carried into the memory stage |
| memTakeBranch | output | 1 | Branch taken, for the next-PC mux |
| wbMemToReg | output | 1 | Writeback value select |
| wbRegWrite | output | 1 | Register-file write enable |
| wbDstReg | output | REG_W | Register-file write address |

## Verification
On every cycle after reset, the assertions check that each stage's control group equals the decode inputs from one, two or three edges earlier. They also check that invalid slots never reach writeback with a write enable, that the zero flag arrives one edge after execute, and that the writeback address equals the execute destination from two edges earlier. Three things show up only in the bench's scenarios: the choice between the rt and rd fields, the clearing effect of a reset in the middle of a stream, and the pairing of each destination with its own instruction while five distinct instructions are in flight. The bench shows these through streams of loads, stores, branches and register operations, interleaved bubbles, and random traffic.

// File: rtl/pipeCtlPkg.sv
package pipeCtlPkg;
  localparam int ALU_OP_W = 2;
  localparam int REG_W    = 5;

  typedef struct packed {
    logic                aluSrc;
    logic [ALU_OP_W-1:0] aluOp;
    logic                regDst;
  } exGrp_t;

  typedef struct packed {
    logic branch;
    logic memRead;
    logic memWrite;
  } memGrp_t;

  typedef struct packed {
    logic regWrite;
    logic memToReg;
  } wbGrp_t;

  // strobes from the control stages to the destination datapath
  typedef struct packed {
    logic clr;
    logic selRd;
  } dstStrobe_t;
endpackage

// File: rtl/pipeCtlStages.sv
module pipeCtlStages
  import pipeCtlPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       idValid,
  input  exGrp_t     idEx,
  input  memGrp_t    idMem,
  input  wbGrp_t     idWb,
  input  logic       exZero,
  output exGrp_t     exCtl,
  output memGrp_t    memCtl,
  output logic       memZero,
  output wbGrp_t     wbCtl,
  output dstStrobe_t strb
);
  exGrp_t  idExEx;
  memGrp_t idExMem, exMemMem;
  wbGrp_t  idExWb, exMemWb, memWbWb;
  logic    exMemZero;
  logic [1:0] upCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      idExEx    <= '0;
      idExMem   <= '0;
      idExWb    <= '0;
      exMemMem  <= '0;
      exMemWb   <= '0;
      exMemZero <= 1'b0;
      memWbWb   <= '0;
    end else begin
      idExEx    <= idValid ? idEx  : '0;
      idExMem   <= idValid ? idMem : '0;
      idExWb    <= idValid ? idWb  : '0;
      exMemMem  <= idExMem;
      exMemWb   <= idExWb;
      exMemZero <= exZero;
      memWbWb   <= exMemWb;
    end
  end

  // cycles since reset, saturating; used only to qualify history checks
  always_ff @(posedge clk) begin
    if (rst) upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  assign exCtl      = idExEx;
  assign memCtl     = exMemMem;
  assign memZero    = exMemZero;
  assign wbCtl      = memWbWb;
  assign strb.clr   = rst;
  assign strb.selRd = idExEx.regDst;

  AST_EX_FROM_ID: assert property (@(posedge clk) disable iff (rst)
    (upCnt != 2'd0) |-> exCtl == ($past(idValid) ? $past(idEx) : '0)); // R1
  AST_MEM_FROM_ID: assert property (@(posedge clk) disable iff (rst)
    (upCnt >= 2'd2) |-> memCtl == ($past(idValid, 2) ? $past(idMem, 2) : '0)); // R3
  AST_ZERO_CARRY: assert property (@(posedge clk) disable iff (rst)
    (upCnt != 2'd0) |-> memZero == $past(exZero)); // R4
  AST_WB_FROM_ID: assert property (@(posedge clk) disable iff (rst)
    (upCnt == 2'd3) |-> wbCtl == ($past(idValid, 3) ? $past(idWb, 3) : '0)); // R5
  AST_BUBBLE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (upCnt == 2'd3 && !$past(idValid, 3)) |-> !wbCtl.regWrite); // R7
endmodule

// File: rtl/pipeDstPath.sv
module pipeDstPath
  import pipeCtlPkg::*;
(
  input  logic             clk,
  input  dstStrobe_t       strb,
  input  logic [REG_W-1:0] idRt,
  input  logic [REG_W-1:0] idRd,
  output logic [REG_W-1:0] exDst,
  output logic [REG_W-1:0] wbDst
);
  logic [REG_W-1:0] idExRt, idExRd, exMemDst, memWbDst;
  logic [1:0] upCnt;

  assign exDst = strb.selRd ? idExRd : idExRt;
  assign wbDst = memWbDst;

  always_ff @(posedge clk) begin
    if (strb.clr) begin
      idExRt   <= '0;
      idExRd   <= '0;
      exMemDst <= '0;
      memWbDst <= '0;
    end else begin
      idExRt   <= idRt;
      idExRd   <= idRd;
      exMemDst <= exDst;
      memWbDst <= exMemDst;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.clr) upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  AST_DST_TRAVELS: assert property (@(posedge clk) disable iff (strb.clr)
    (upCnt >= 2'd2) |-> wbDst == $past(exDst, 2)); // R6
  AST_DST_IS_FIELD: assert property (@(posedge clk) disable iff (strb.clr)
    (upCnt != 2'd0) |-> (exDst == $past(idRt) || exDst == $past(idRd))); // R2
endmodule

// File: rtl/pipeCtlShifter.sv
module pipeCtlShifter
  import pipeCtlPkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                idValid,
  input  logic                idAluSrc,
  input  logic [ALU_OP_W-1:0] idAluOp,
  input  logic                idRegDst,
  input  logic                idBranch,
  input  logic                idMemRead,
  input  logic                idMemWrite,
  input  logic                idRegWrite,
  input  logic                idMemToReg,
  input  logic [REG_W-1:0]    idRtField,
  input  logic [REG_W-1:0]    idRdField,
  input  logic                exZero,
  output logic                exAluSrc,
  output logic [ALU_OP_W-1:0] exAluOp,
  output logic [REG_W-1:0]    exDstReg,
  output logic                memBranch,
  output logic                memRead,
  output logic                memWrite,
  output logic                memZero,
  output logic                memTakeBranch,
  output logic                wbMemToReg,
  output logic                wbRegWrite,
  output logic [REG_W-1:0]    wbDstReg
);
  exGrp_t     idEx, exCtl;
  memGrp_t    idMem, memCtl;
  wbGrp_t     idWb, wbCtl;
  dstStrobe_t strb;

  assign idEx  = '{aluSrc: idAluSrc, aluOp: idAluOp, regDst: idRegDst};
  assign idMem = '{branch: idBranch, memRead: idMemRead, memWrite: idMemWrite};
  assign idWb  = '{regWrite: idRegWrite, memToReg: idMemToReg};

  pipeCtlStages u_ctl (
    .clk(clk), .rst(rst), .idValid(idValid),
    .idEx(idEx), .idMem(idMem), .idWb(idWb), .exZero(exZero),
    .exCtl(exCtl), .memCtl(memCtl), .memZero(memZero), .wbCtl(wbCtl),
    .strb(strb)
  );

  pipeDstPath u_dst (
    .clk(clk), .strb(strb), .idRt(idRtField), .idRd(idRdField),
    .exDst(exDstReg), .wbDst(wbDstReg)
  );

  assign exAluSrc      = exCtl.aluSrc;
  assign exAluOp       = exCtl.aluOp;
  assign memBranch     = memCtl.branch;
  assign memRead       = memCtl.memRead;
  assign memWrite      = memCtl.memWrite;
  assign memTakeBranch = memCtl.branch & memZero;
  assign wbRegWrite    = wbCtl.regWrite;
  assign wbMemToReg    = wbCtl.memToReg;
endmodule

// File: tb/pipeCtlShifter_bench.sv
module pipeCtlShifter_bench;
  import pipeCtlPkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, idValid, idAluSrc, idRegDst, idBranch, idMemRead, idMemWrite;
  logic idRegWrite, idMemToReg, exZero;
  logic [ALU_OP_W-1:0] idAluOp;
  logic [REG_W-1:0] idRtField, idRdField;
  logic exAluSrc, memBranch, memRead, memWrite, memZero, memTakeBranch;
  logic wbMemToReg, wbRegWrite;
  logic [ALU_OP_W-1:0] exAluOp;
  logic [REG_W-1:0] exDstReg, wbDstReg;

  pipeCtlShifter u_pipeCtlShifter (.*);

  localparam int DEPTH = 4096;
  logic rRst[DEPTH], rVal[DEPTH], rSrc[DEPTH], rRdst[DEPTH], rBr[DEPTH];
  logic rMr[DEPTH], rMw[DEPTH], rRw[DEPTH], rM2r[DEPTH], rZ[DEPTH];
  logic [ALU_OP_W-1:0] rOp[DEPTH];
  logic [REG_W-1:0] rRt[DEPTH], rRd[DEPTH];
  int cyc = 0;
  int nChk = 0, nErr = 0;

  // behavioural history of what was presented at each edge
  always @(posedge clk) begin
    rRst[cyc] = rst; rVal[cyc] = idValid; rSrc[cyc] = idAluSrc; rOp[cyc] = idAluOp;
    rRdst[cyc] = idRegDst; rBr[cyc] = idBranch; rMr[cyc] = idMemRead;
    rMw[cyc] = idMemWrite; rRw[cyc] = idRegWrite; rM2r[cyc] = idMemToReg;
    rRt[cyc] = idRtField; rRd[cyc] = idRdField; rZ[cyc] = exZero;
    cyc = cyc + 1;
  end

  function automatic logic live(int e);
    return !rRst[e] && rVal[e];
  endfunction

  function automatic logic [REG_W-1:0] dstOf(int e);
    if (rRst[e]) return '0;
    return (live(e) && rRdst[e]) ? rRd[e] : rRt[e];
  endfunction

  task automatic chk(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s at edge %0d: actual=%0h expected=%0h", tag, cyc - 1, act, exp);
    end
  endtask

  task automatic compare();
    int t = cyc - 1;
    logic mLive, wLive, expZ;
    if (t < 2) return;
    // execute stage
    chk(rRst[t] ? "R8 ex ctl" : (!rVal[t] ? "R7 ex ctl" : "R1 ex ctl"),
        {exAluSrc, exAluOp}, live(t) ? {rSrc[t], rOp[t]} : 0);
    chk(rRst[t] ? "R8 ex dst" : "R2 ex dst", exDstReg, dstOf(t));
    // memory stage
    mLive = !rRst[t] && live(t - 1);
    chk((rRst[t] || rRst[t-1]) ? "R8 mem ctl" : (!rVal[t-1] ? "R7 mem ctl" : "R3 mem ctl"),
        {memBranch, memRead, memWrite}, mLive ? {rBr[t-1], rMr[t-1], rMw[t-1]} : 0);
    expZ = rRst[t] ? 1'b0 : rZ[t];
    chk("R4 zero", {memZero, memTakeBranch}, {expZ, mLive & rBr[t-1] & expZ});
    // writeback stage
    wLive = !rRst[t] && !rRst[t-1] && live(t - 2);
    chk((rRst[t] || rRst[t-1] || rRst[t-2]) ? "R8 wb ctl" :
        (!rVal[t-2] ? "R7 wb ctl" : "R5 wb ctl"),
        {wbRegWrite, wbMemToReg}, wLive ? {rRw[t-2], rM2r[t-2]} : 0);
    chk((rRst[t] || rRst[t-1]) ? "R8 wb dst" : "R6 wb dst", wbDstReg,
        (rRst[t] || rRst[t-1]) ? 0 : dstOf(t - 2));
  endtask

  task automatic step(logic r, logic v, logic src, logic [ALU_OP_W-1:0] op, logic rdst,
                      logic br, logic mr, logic mw, logic rw, logic m2r,
                      logic [REG_W-1:0] rt, logic [REG_W-1:0] rd, logic z);
    @(negedge clk);
    compare();
    rst = r; idValid = v; idAluSrc = src; idAluOp = op; idRegDst = rdst;
    idBranch = br; idMemRead = mr; idMemWrite = mw; idRegWrite = rw;
    idMemToReg = m2r; idRtField = rt; idRdField = rd; exZero = z;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nErr++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; idValid = 1'b1; idAluSrc = 1'b1; idAluOp = '1; idRegDst = 1'b1;
    idBranch = 1'b1; idMemRead = 1'b1; idMemWrite = 1'b1; idRegWrite = 1'b1;
    idMemToReg = 1'b1; idRtField = '1; idRdField = '1; exZero = 1'b1;
    // reset with busy inputs: R8
    for (int i = 0; i < 4; i++) step(1, 1, 1, '1, 1, 1, 1, 1, 1, 1, 5'd31, 5'd31, 1);
    // register-type stream, rd destination, distinct numbers: R2 R6
    for (int i = 0; i < 10; i++)
      step(0, 1, 0, ALU_OP_W'(2), 1, 0, 0, 0, 1, 0, REG_W'(i + 1), REG_W'(20 + i), 0);
    // loads, rt destination: R2 R5
    for (int i = 0; i < 6; i++)
      step(0, 1, 1, '0, 0, 0, 1, 0, 1, 1, REG_W'(8 + i), REG_W'(3), 1);
    // stores and branches with alternating zero flag: R3 R4
    for (int i = 0; i < 8; i++)
      step(0, 1, i[0], ALU_OP_W'(i), 0, i[0], 0, !i[0], 0, 0, REG_W'(i), REG_W'(31 - i), i[1]);
    // bubbles interleaved with writes, control fields driven high: R7
    for (int i = 0; i < 10; i++)
      step(0, i[0], 1, '1, 1, 1, 1, 1, 1, 1, REG_W'(i), REG_W'(i + 10), 1);
    // random traffic
    for (int i = 0; i < 160; i++) begin
      logic [31:0] w = $urandom;
      step(0, w[0] | w[1], w[2], w[4:3], w[5], w[6], w[7], w[8], w[9], w[10],
           w[15:11], w[20:16], w[21]);
    end
    // reset in the middle of a stream: R8
    for (int i = 0; i < 3; i++)
      step(0, 1, 1, '1, 1, 1, 1, 1, 1, 1, 5'd7, 5'd9, 1);
    step(1, 1, 1, '1, 1, 1, 1, 1, 1, 1, 5'd7, 5'd9, 1);
    for (int i = 0; i < 4; i++)
      step(0, 1, 0, ALU_OP_W'(1), 1, 0, 0, 0, 1, 0, REG_W'(i), REG_W'(16 + i), 0);
    // drain
    for (int i = 0; i < 5; i++) step(0, 0, 0, '0, 0, 0, 0, 0, 0, 0, '0, '0, 0);
    @(negedge clk);
    compare();
    summary();
    $finish;
  end
endmodule